// File: doc/BRIEF.md
# Subword Vector DSP ALU Lane

This block is one 64-bit integer lane of a vector unit. Each operation chooses how the lane is split: four 16-bit elements, two 32-bit elements or one 64-bit element. Every element is handled on its own, so no carry and no shifted bit crosses into a neighbouring element. The lane can add, subtract, multiply, shift left and shift right, on signed or unsigned values. The block has no register file, no floating point and no divider.

The first operand, the second operand, or neither can be taken from a scalar input that is copied into every element. An optional DSP step shifts the second operand right before the operation and rounds it in one of three ways. Results that overflow can be clamped to the limits of the element type, or left to wrap.

The result is registered and appears one cycle after the operation. It comes with write enables, one per 16-bit slot. A masked operation uses one flag per element to suppress the write of that element.

Top module: `simd_dsp_lane`

## Requirements
- R1: `ew_sel` picks the element width: 0 gives four 16-bit elements, 1 gives two 32-bit elements, 2 gives one 64-bit element, and 3 behaves as 2. Element e occupies bits [e*EW +: EW]. Carries and shifted bits stay inside their own element.
- R2: When `sat_en` is 0, `op` 0 (add) and `op` 1 (subtract, first minus second) wrap modulo 2^EW in each element.
- R3: `op` 2 (multiply) returns the low EW bits of each element product when `sat_en` is 0.
- R4: `op` 3 shifts left and `op` 4 shifts right. The shift amount is the low log2(EW) bits of the element's second operand. A right shift is arithmetic when `is_signed` is 1 and logical when it is 0.
- R5: `form` chooses the operand source. 0 takes both operands from the vectors. 1 replaces the second operand with the low EW bits of `scalar`, copied into every element. 2 replaces the first operand in the same way. 3 behaves as 0.
- R6: When `dsp_en` is 1, the second operand of each element is first shifted right by the low log2(EW) bits of `pre_shift`. The shift is arithmetic when signed. The result is then rounded according to `rnd_mode`:
  - 0 truncates.
  - 1 adds the highest bit shifted out.
  - 2 rounds half to even: it adds that bit only when a lower shifted-out bit or the kept LSB is 1.
  - 3 truncates.
- R7: When `sat_en` is 1, an add, subtract or multiply whose exact result lies outside the element type clamps to the nearest limit. Signed limits are 2^(EW-1)-1 and -2^(EW-1); unsigned limits are 2^EW-1 and 0. A left shift that loses significant bits clamps to the maximum, or to the signed minimum when the operand is negative. A right shift never clamps.
- R8: `out_valid` follows `in_valid` by exactly one clock. `out_data` and `out_we` are registered with one cycle of latency.
- R9: `out_we` has one bit per 16-bit slot, and slot s belongs to element s>>ew_sel. With `masked` = 0, all bits are 1. With `masked` = 1, a slot's bit equals `elem_mask` of its element. All bits are 0 whenever `out_valid` is 0.
- R10: `op` codes 5 to 7 produce an all-zero result.
- R11: While `rst_n` is low, `out_valid`, `out_data` and `out_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 shl, 4 shr) |
| ew_sel | input | 2 | Element width select |
| form | input | 2 | Operand source form |
| is_signed | input | 1 | Signed element interpretation |
| sat_en | input | 1 | Clamp on overflow |
| dsp_en | input | 1 | Pre-shift and round the second operand |
| rnd_mode | input | 2 | Rounding mode for the pre-shift |
| pre_shift | input | 6 | Pre-shift amount (low log2(EW) bits used) |
| masked | input | 1 | Use per-element flags for the write enables |
| elem_mask | input | 4 | Per-element write flags |
| vec_a | input | 64 | First vector operand |
| vec_b | input | 64 | Second vector operand |
| scalar | input | 64 | Scalar operand for the mixed forms |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Lane result |
| out_we | output | 4 | Per-16-bit-slot write enables |

## Verification
The bench drives operands whose sums cross the 16-bit slot boundaries. A lane that leaked carries between elements would corrupt the neighbouring element. A lane that ignored `ew_sel` would give the same value at every width.

Saturation is tested at both signed limits, at unsigned underflow, on a multiply whose low half is zero, and on left shifts that flip the sign. A design that wrapped instead would return values such as 0x0000 or 0x8000 where a clamp is required.

Rounding is tested on exact ties with an odd and with an even kept LSB, on negative operands and on a 64-bit pre-shift. This separates half-up from half-even and exposes a logical shift used where an arithmetic one is needed.

Further tests cover:
- masks at every width, where a wrong slot-to-element mapping would enable the wrong 16-bit slots;
- the scalar forms, where a design that swapped them would subtract in the wrong direction.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4
  } lane_op_e;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'd0,
    RND_HALF_UP   = 2'd1,
    RND_HALF_EVEN = 2'd2
  } rnd_e;

  typedef enum logic [1:0] {
    FORM_VV = 2'd0,
    FORM_VS = 2'd1,
    FORM_SV = 2'd2
  } form_e;

  typedef struct packed {
    logic [2:0] op;
    logic       is_signed;
    logic       sat_en;
    logic       dsp_en;
    logic [1:0] rnd;
  } elem_ctl_t;

endpackage

// File: rtl/sdl_operand_sel.sv
module sdl_operand_sel
  import sdl_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int EW     = 16
) (
  input  logic [1:0]        form,
  input  logic [LANE_W-1:0] vec_a,
  input  logic [LANE_W-1:0] vec_b,
  input  logic [EW-1:0]     scal_elem,
  output logic [LANE_W-1:0] opa,
  output logic [LANE_W-1:0] opb
);
  localparam int NE = LANE_W / EW;

  logic [LANE_W-1:0] rep;
  assign rep = {NE{scal_elem}};

  always_comb begin
    case (form)
      FORM_VS: begin
        opa = vec_a;
        opb = rep;
      end
      FORM_SV: begin
        opa = rep;
        opb = vec_b;
      end
      default: begin
        opa = vec_a;
        opb = vec_b;
      end
    endcase
  end
endmodule

// File: rtl/sdl_elem_unit.sv
module sdl_elem_unit
  import sdl_pkg::*;
#(
  parameter int EW = 16
) (
  input  elem_ctl_t                 ctl,
  input  logic [EW-1:0]             a,
  input  logic [EW-1:0]             b,
  input  logic [$clog2(EW)-1:0]     pre_sh,
  output logic [EW-1:0]             res,
  output logic                      ovf
);
  localparam int SHW = $clog2(EW);
  localparam int PW  = 2 * EW + 2;

  // second operand: shift right, then round by the selected mode
  function automatic logic [EW-1:0] prescale(logic [EW-1:0] v, logic [SHW-1:0] sh,
                                              logic sgn, logic [1:0] rnd);
    logic [EW-1:0] kept;
    logic [EW-1:0] low_mask;
    logic          guard;
    logic          sticky;
    logic          lsb;
    logic          inc;
    int            shi;
    shi = int'(sh);
    if (shi == 0) return v;
    kept     = sgn ? EW'($signed(v) >>> sh) : (v >> sh);
    guard    = v[shi-1];
    low_mask = (EW'(1) << (shi - 1)) - EW'(1);
    sticky   = |(v & low_mask);
    lsb      = v[shi];
    case (rnd)
      RND_HALF_UP:   inc = guard;
      RND_HALF_EVEN: inc = guard & (sticky | lsb);
      default:       inc = 1'b0;
    endcase
    return kept + EW'(inc);
  endfunction

  function automatic logic signed [PW-1:0] widen(logic [EW-1:0] v, logic sgn);
    if (sgn) return PW'($signed(v));
    return PW'(v);
  endfunction

  function automatic logic out_of_range(logic signed [PW-1:0] w, logic sgn);
    logic signed [PW-1:0] one;
    logic signed [PW-1:0] hi;
    logic signed [PW-1:0] lo;
    one = PW'(1);
    if (sgn) begin
      hi = (one <<< (EW - 1)) - one;
      lo = -(one <<< (EW - 1));
    end else begin
      hi = (one <<< EW) - one;
      lo = '0;
    end
    return (w > hi) || (w < lo);
  endfunction

  function automatic logic [EW-1:0] limit(logic neg, logic sgn);
    if (sgn) return neg ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
    return neg ? '0 : '1;
  endfunction

  function automatic logic shl_lost(logic [EW-1:0] v, logic [EW-1:0] r,
                                    logic [SHW-1:0] sh, logic sgn);
    if (sgn) return ($signed(r) >>> sh) != $signed(v);
    return (r >> sh) != v;
  endfunction

  logic [EW-1:0]        bp;
  logic [SHW-1:0]       amt;
  logic signed [PW-1:0] wa;
  logic signed [PW-1:0] wb;
  logic signed [PW-1:0] wide;
  logic [EW-1:0]        raw;
  logic                 neg;

  always_comb begin
    bp   = ctl.dsp_en ? prescale(b, pre_sh, ctl.is_signed, ctl.rnd) : b;
    amt  = bp[SHW-1:0];
    wa   = widen(a, ctl.is_signed);
    wb   = widen(bp, ctl.is_signed);
    wide = '0;
    raw  = '0;
    neg  = 1'b0;
    ovf  = 1'b0;
    case (ctl.op)
      OP_ADD, OP_SUB, OP_MUL: begin
        if (ctl.op == OP_ADD)      wide = wa + wb;
        else if (ctl.op == OP_SUB) wide = wa - wb;
        else                       wide = wa * wb;
        raw = wide[EW-1:0];
        neg = wide[PW-1];
        ovf = out_of_range(wide, ctl.is_signed);
      end
      OP_SHL: begin
        raw = a << amt;
        neg = ctl.is_signed & a[EW-1];
        ovf = shl_lost(a, raw, amt, ctl.is_signed);
      end
      OP_SHR: begin
        raw = ctl.is_signed ? EW'($signed(a) >>> amt) : (a >> amt);
      end
      default: raw = '0;
    endcase
    res = (ctl.sat_en && ovf) ? limit(neg, ctl.is_signed) : raw;
  end
endmodule

// File: rtl/simd_dsp_lane.sv
module simd_dsp_lane
  import sdl_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int SLOT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [2:0]                        op,
  input  logic [1:0]                        ew_sel,
  input  logic [1:0]                        form,
  input  logic                              is_signed,
  input  logic                              sat_en,
  input  logic                              dsp_en,
  input  logic [1:0]                        rnd_mode,
  input  logic [$clog2(LANE_W)-1:0]         pre_shift,
  input  logic                              masked,
  input  logic [LANE_W/SLOT_W-1:0]          elem_mask,
  input  logic [LANE_W-1:0]                 vec_a,
  input  logic [LANE_W-1:0]                 vec_b,
  input  logic [LANE_W-1:0]                 scalar,
  output logic                              out_valid,
  output logic [LANE_W-1:0]                 out_data,
  output logic [LANE_W/SLOT_W-1:0]          out_we
);
  localparam int NSLOT  = LANE_W / SLOT_W;
  localparam int NWID   = $clog2(NSLOT) + 1;
  localparam int WSEL_W = 2;

  elem_ctl_t ctl;
  assign ctl = '{op: op, is_signed: is_signed, sat_en: sat_en,
                 dsp_en: dsp_en, rnd: rnd_mode};

  logic [NWID-1:0][LANE_W-1:0] res_w;
  logic [NWID-1:0][NSLOT-1:0]  we_w;
  logic [NWID-1:0]             ovf_w;

  for (genvar k = 0; k < NWID; k++) begin : g_wid
    localparam int EW  = SLOT_W << k;
    localparam int NE  = LANE_W / EW;
    localparam int SHW = $clog2(EW);

    logic [LANE_W-1:0] opa;
    logic [LANE_W-1:0] opb;
    logic [LANE_W-1:0] res_k;
    logic [NE-1:0]     ovf_e;

    sdl_operand_sel #(.LANE_W(LANE_W), .EW(EW)) u_sel (
      .form      (form),
      .vec_a     (vec_a),
      .vec_b     (vec_b),
      .scal_elem (scalar[EW-1:0]),
      .opa       (opa),
      .opb       (opb)
    );

    for (genvar e = 0; e < NE; e++) begin : g_elem
      sdl_elem_unit #(.EW(EW)) u_unit (
        .ctl    (ctl),
        .a      (opa[e*EW +: EW]),
        .b      (opb[e*EW +: EW]),
        .pre_sh (pre_shift[SHW-1:0]),
        .res    (res_k[e*EW +: EW]),
        .ovf    (ovf_e[e])
      );
    end

    assign res_w[k] = res_k;
    assign ovf_w[k] = |ovf_e;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign we_w[k][s] = !masked | elem_mask[s >> k];
    end
  end

  // width codes past the widest variant fall back to the widest
  logic [WSEL_W-1:0] widx;
  assign widx = (ew_sel > WSEL_W'(NWID - 1)) ? WSEL_W'(NWID - 1) : ew_sel;

  logic [LANE_W-1:0] sel_res;
  logic [NSLOT-1:0]  sel_we;
  logic              any_ovf;
  assign sel_res = res_w[widx];
  assign sel_we  = we_w[widx];
  assign any_ovf = ovf_w[widx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid ? sel_we : '0;
      if (in_valid) out_data <= sel_res;
    end
  end
endmodule

// File: rtl/sdl_lane_checker.sv
module sdl_lane_checker #(
  parameter int NSLOT  = 4,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [WSEL_W-1:0] ew_sel,
  input logic              masked,
  input logic [NSLOT-1:0]  elem_mask,
  input logic              out_valid,
  input logic [NSLOT-1:0]  out_we,
  input logic              any_ovf
);
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_we_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_we == '0));

  assert_unmasked_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !masked) |=> (out_we == {NSLOT{1'b1}}));

  assert_mask_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && masked && ew_sel == '0) |=> (out_we == $past(elem_mask)));

  assert_shr_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |-> !any_ovf);

  assert_spare_op_no_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 3'd4) |-> !any_ovf);
endmodule

bind simd_dsp_lane sdl_lane_checker #(.NSLOT(NSLOT), .WSEL_W(WSEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .ew_sel    (ew_sel),
  .masked    (masked),
  .elem_mask (elem_mask),
  .out_valid (out_valid),
  .out_we    (out_we),
  .any_ovf   (any_ovf)
);

// File: tb/simd_dsp_lane_test.sv
module simd_dsp_lane_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  ew_sel = '0;
  logic [1:0]  form = '0;
  logic        is_signed = 1'b0;
  logic        sat_en = 1'b0;
  logic        dsp_en = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic [5:0]  pre_shift = '0;
  logic        masked = 1'b0;
  logic [3:0]  elem_mask = '0;
  logic [63:0] vec_a = '0;
  logic [63:0] vec_b = '0;
  logic [63:0] scalar = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [3:0]  out_we;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  simd_dsp_lane uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ew_sel(ew_sel),
    .form(form), .is_signed(is_signed), .sat_en(sat_en), .dsp_en(dsp_en),
    .rnd_mode(rnd_mode), .pre_shift(pre_shift), .masked(masked),
    .elem_mask(elem_mask), .vec_a(vec_a), .vec_b(vec_b), .scalar(scalar),
    .out_valid(out_valid), .out_data(out_data), .out_we(out_we)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] o, logic [1:0] w, logic [1:0] f, logic sg,
                     logic st, logic dp, logic [1:0] rm, logic [5:0] sh);
    op = o; ew_sel = w; form = f; is_signed = sg; sat_en = st;
    dsp_en = dp; rnd_mode = rm; pre_shift = sh; masked = 1'b0;
  endtask

  // drive one operation, then sample the registered result a cycle later
  task automatic issue(logic [63:0] a, logic [63:0] b, logic [63:0] s);
    @(negedge clk);
    vec_a = a; vec_b = b; scalar = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(string tag, logic [63:0] a, logic [63:0] b,
                     logic [63:0] s, logic [63:0] exp);
    issue(a, b, s);
    chk(tag, out_data, exp);
  endtask

  task automatic t_reset;
    chk("R11 reset valid", 64'(out_valid), 64'd0);
    chk("R11 reset data", out_data, 64'd0);
    chk("R11 reset we", 64'(out_we), 64'd0);
  endtask

  task automatic t_add_widths;
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    run("R1 R2 add w16", 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 0,
        64'h0002_0000_8000_0000);
    cfg(3'd0, 2'd2, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    run("R1 R2 add w64", 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 0,
        64'h0003_0000_8001_0000);
    cfg(3'd0, 2'd3, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    run("R1 width code 3", 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 0,
        64'h0003_0000_8001_0000);
    cfg(3'd1, 2'd0, 2'd0, 1, 0, 0, 2'd0, 6'd0);
    run("R2 sub wrap w16", 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0001_0003, 0,
        64'h7FFF_8000_FFFF_0002);
  endtask

  task automatic t_saturate;
    cfg(3'd1, 2'd0, 2'd0, 1, 1, 0, 2'd0, 6'd0);
    run("R7 signed sub sat", 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0001_0003, 0,
        64'h8000_7FFF_FFFF_0002);
    cfg(3'd1, 2'd0, 2'd0, 0, 1, 0, 2'd0, 6'd0);
    run("R7 unsigned sub sat", 64'h8000_7FFF_0000_0005, 64'h0001_FFFF_0001_0003, 0,
        64'h7FFF_0000_0000_0002);
    cfg(3'd0, 2'd0, 2'd0, 0, 1, 0, 2'd0, 6'd0);
    run("R7 unsigned add sat", 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 0,
        64'h0002_FFFF_8000_FFFF);
    cfg(3'd0, 2'd0, 2'd0, 1, 1, 0, 2'd0, 6'd0);
    run("R7 signed add sat", 64'h0001_FFFF_7FFF_8000, 64'h0001_0001_0001_8000, 0,
        64'h0002_0000_7FFF_8000);
    cfg(3'd3, 2'd0, 2'd0, 1, 1, 0, 2'd0, 6'd0);
    run("R7 shl sat", 64'h4000_0001_C000_8000, 64'h0001_0001_0001_0001, 0,
        64'h7FFF_0002_8000_8000);
  endtask

  task automatic t_mul;
    cfg(3'd2, 2'd1, 2'd0, 1, 0, 0, 2'd0, 6'd0);
    run("R3 mul low half w32", 64'h0001_0000_FFFF_FFFF, 64'h0001_0000_0000_0003, 0,
        64'h0000_0000_FFFF_FFFD);
    cfg(3'd2, 2'd1, 2'd0, 1, 1, 0, 2'd0, 6'd0);
    run("R7 mul sat w32", 64'h0001_0000_FFFF_FFFF, 64'h0001_0000_0000_0003, 0,
        64'h7FFF_FFFF_FFFF_FFFD);
  endtask

  task automatic t_shift;
    cfg(3'd3, 2'd0, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    run("R4 shl w16", 64'h0001_8001_00F0_1234, 64'h0004_0001_0010_0000, 0,
        64'h0010_0002_00F0_1234);
    cfg(3'd4, 2'd0, 2'd0, 1, 0, 0, 2'd0, 6'd0);
    run("R4 shr signed", 64'h8000_8000_7FFF_FFF0, 64'h0004_0004_0001_0004, 0,
        64'hF800_F800_3FFF_FFFF);
    cfg(3'd4, 2'd0, 2'd0, 0, 1, 0, 2'd0, 6'd0);
    run("R4 R7 shr unsigned", 64'h8000_8000_7FFF_FFF0, 64'h0004_0004_0001_0004, 0,
        64'h0800_0800_3FFF_0FFF);
  endtask

  task automatic t_forms;
    cfg(3'd0, 2'd0, 2'd1, 0, 0, 0, 2'd0, 6'd0);
    run("R5 vector-scalar w16", 64'h0001_0002_0003_0004, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hDEAD_BEEF_0000_0010, 64'h0011_0012_0013_0014);
    cfg(3'd0, 2'd1, 2'd1, 0, 0, 0, 2'd0, 6'd0);
    run("R5 vector-scalar w32", 64'h0001_0002_0003_0004, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hDEAD_BEEF_0000_0010, 64'h0001_0012_0003_0014);
    cfg(3'd1, 2'd0, 2'd2, 0, 0, 0, 2'd0, 6'd0);
    run("R5 scalar-vector sub", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0002_0003_0004,
        64'h0000_0000_0000_0010, 64'h000F_000E_000D_000C);
    cfg(3'd1, 2'd0, 2'd3, 0, 0, 0, 2'd0, 6'd0);
    run("R5 form 3 as vector", 64'h0010_0010_0010_0010, 64'h0001_0002_0003_0004,
        64'h0000_0000_0000_00FF, 64'h000F_000E_000D_000C);
  endtask

  task automatic t_dsp_round;
    // pre_shift 18 -> low 4 bits = 2 in 16-bit mode
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 1, 2'd0, 6'd18);
    run("R6 truncate", 64'd0, 64'h0006_000A_0005_0007, 0, 64'h0001_0002_0001_0001);
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 1, 2'd1, 6'd18);
    run("R6 half up", 64'd0, 64'h0006_000A_0005_0007, 0, 64'h0002_0003_0001_0002);
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 1, 2'd2, 6'd18);
    run("R6 half even", 64'd0, 64'h0006_000A_0005_0007, 0, 64'h0002_0002_0001_0002);
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 1, 2'd3, 6'd18);
    run("R6 mode 3 truncates", 64'd0, 64'h0006_000A_0005_0007, 0, 64'h0001_0002_0001_0001);
    cfg(3'd0, 2'd0, 2'd0, 1, 0, 1, 2'd1, 6'd2);
    run("R6 signed half up", 64'd0, 64'hFFF8_FFFA_0000_0000, 0, 64'hFFFE_FFFF_0000_0000);
    cfg(3'd0, 2'd2, 2'd0, 0, 0, 1, 2'd1, 6'd40);
    run("R6 w64 half up", 64'd5, 64'h0000_0180_0000_0000, 0, 64'd7);
    cfg(3'd0, 2'd2, 2'd0, 0, 0, 1, 2'd0, 6'd40);
    run("R6 w64 truncate", 64'd5, 64'h0000_0180_0000_0000, 0, 64'd6);
  endtask

  task automatic t_mask;
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    masked = 1'b1; elem_mask = 4'b0101;
    issue(64'd1, 64'd1, 0);
    chk("R9 mask w16", 64'(out_we), 64'h5);
    ew_sel = 2'd1; elem_mask = 4'b1110;
    issue(64'd1, 64'd1, 0);
    chk("R9 mask w32", 64'(out_we), 64'hC);
    ew_sel = 2'd2; elem_mask = 4'b0001;
    issue(64'd1, 64'd1, 0);
    chk("R9 mask w64", 64'(out_we), 64'hF);
    masked = 1'b0; elem_mask = 4'b0000; ew_sel = 2'd0;
    issue(64'd1, 64'd1, 0);
    chk("R9 unmasked", 64'(out_we), 64'hF);
  endtask

  task automatic t_opcode_latency;
    cfg(3'd5, 2'd0, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    run("R10 spare opcode", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0, 64'd0);
    cfg(3'd0, 2'd0, 2'd0, 0, 0, 0, 2'd0, 6'd0);
    @(negedge clk);
    vec_a = 64'd3; vec_b = 64'd4; in_valid = 1'b1;
    #1 chk("R8 not valid before edge", 64'(out_valid), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid after one edge", 64'(out_valid), 64'd1);
    chk("R8 data after one edge", out_data, 64'd7);
    @(negedge clk);
    chk("R8 valid drops", 64'(out_valid), 64'd0);
    chk("R9 we clear when idle", 64'(out_we), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_widths();
    t_saturate();
    t_mul();
    t_shift();
    t_forms();
    t_dsp_round();
    t_mask();
    t_opcode_latency();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule